// File: doc/BRIEF.md
# Rotating Floating-Point Register Stack

This block keeps eight floating-point words in a circular array and names them relative to a moving top-of-stack pointer, not by fixed register numbers. An operand written as ST(i) resolves to physical slot (top + i) mod 8. Because of this, the same physical register appears under a different stack name after every push or pop, and any ST(i) can land on any of the eight slots.

Transfers to and from memory always go through ST(0). A load is a push that places the incoming word on the new top. A store reads the word currently shown as ST(0). A store-and-discard is a pop. An exchange swaps ST(0) with any ST(i) in a single cycle.

Two relative read ports let an execution unit fetch operands by stack name. Each port comes with a "full" indication. Each slot carries a tag bit marking it empty or full. A push onto a full slot is refused and raises an overflow pulse. A pop or exchange that touches an empty slot is refused and raises an underflow pulse.

Top module: `fp_reg_stack`

## Requirements
- R1: After reset the top pointer reads 0, every slot is empty (both read ports report not full), and both fault outputs are low.
- R2: A read port given relative index i returns the data and tag of physical slot (top + i) mod 8, combinationally.
- R3: Operation code 2'b01 (push) decrements the top pointer by one modulo 8 and writes the load word into the new ST(0); each former ST(i) becomes ST(i+1).
- R4: The store path always presents ST(0). Operation code 2'b10 (pop) marks ST(0) empty and increments the top pointer by one modulo 8, so the former ST(1) becomes ST(0).
- R5: A successful push followed by a successful pop leaves the top pointer and the whole ST(i) to physical mapping as before.
- R6: A push whose target slot is already full leaves all state unchanged and drives the overflow output high in the following cycle.
- R7: A pop of an empty ST(0), or an exchange where ST(0) or ST(i) is empty, leaves all state unchanged and drives the underflow output high in the following cycle.
- R8: Operation code 2'b11 (exchange) swaps the contents of ST(0) and ST(i) in one cycle without moving the top pointer; with i = 0 nothing changes.
- R9: Operation code 2'b00 is a no-op. Each fault output is a single-cycle pulse: it is low in any cycle that follows an operation without that fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 2 | Operation: 00 none, 01 push, 10 pop, 11 exchange |
| idx_i | input | 3 | Relative index i for exchange |
| ld_data_i | input | DW | Word loaded from memory on push |
| ra_idx_i | input | 3 | Relative index for read port A |
| rb_idx_i | input | 3 | Relative index for read port B |
| st_data_o | output | DW | Store path, always ST(0) |
| ra_data_o | output | DW | Read port A data |
| ra_full_o | output | 1 | Read port A slot holds a value |
| rb_data_o | output | DW | Read port B data |
| rb_full_o | output | 1 | Read port B slot holds a value |
| top_o | output | 3 | Current top-of-stack pointer |
| ovf_o | output | 1 | Overflow pulse for previous operation |
| unf_o | output | 1 | Underflow pulse for previous operation |

## Verification
Some rules hold on every cycle and are checked there: pointer motion on accepted pushes and pops, the frozen pointer around faults and exchanges, the word pushed showing at once on the store path, the exchanged word arriving in ST(0), and the two fault pulses never rising together. The bench's scenarios are needed for the rest. These are the full ST(i) remapping as the pointer wraps past slot 7, the exact fault conditions at an empty and at a full stack, and the restored mapping after a push/pop pair. A behavioural queue model shows these when it is compared against both read ports on every clock.

// File: rtl/fp_reg_stack.sv
module fp_reg_stack #(
  parameter int DW   = 64,
  parameter int NREG = 8,
  localparam int PW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    op_i,
  input  logic [PW-1:0] idx_i,
  input  logic [DW-1:0] ld_data_i,
  input  logic [PW-1:0] ra_idx_i,
  input  logic [PW-1:0] rb_idx_i,
  output logic [DW-1:0] st_data_o,
  output logic [DW-1:0] ra_data_o,
  output logic          ra_full_o,
  output logic [DW-1:0] rb_data_o,
  output logic          rb_full_o,
  output logic [PW-1:0] top_o,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam logic [1:0] OP_PUSH = 2'b01;
  localparam logic [1:0] OP_POP  = 2'b10;
  localparam logic [1:0] OP_XCHG = 2'b11;

  logic [DW-1:0]   slot [NREG];
  logic [NREG-1:0] full;
  logic [PW-1:0]   top;

  wire [PW-1:0] top_dn = top - 1'b1;
  wire [PW-1:0] top_up = top + 1'b1;
  wire [PW-1:0] x_phys = top + idx_i;
  wire [PW-1:0] a_phys = top + ra_idx_i;
  wire [PW-1:0] b_phys = top + rb_idx_i;

  wire push_req = op_i == OP_PUSH;
  wire pop_req  = op_i == OP_POP;
  wire xchg_req = op_i == OP_XCHG;

  wire push_ok = push_req && !full[top_dn];
  wire pop_ok  = pop_req && full[top];
  wire xchg_ok = xchg_req && full[top] && full[x_phys];

  assign st_data_o = slot[top];
  assign ra_data_o = slot[a_phys];
  assign ra_full_o = full[a_phys];
  assign rb_data_o = slot[b_phys];
  assign rb_full_o = full[b_phys];
  assign top_o     = top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top   <= '0;
      full  <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      ovf_o <= push_req && !push_ok;
      unf_o <= (pop_req && !pop_ok) || (xchg_req && !xchg_ok);
      if (push_ok) begin
        top          <= top_dn;
        full[top_dn] <= 1'b1;
      end else if (pop_ok) begin
        top       <= top_up;
        full[top] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && push_ok)
      slot[top_dn] <= ld_data_i;
    else if (rst_n && xchg_ok) begin
      slot[top]    <= slot[x_phys];
      slot[x_phys] <= slot[top];
    end
  end

  // R3
  push_moves_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> top_o == $past(top_o) - 1'b1 && st_data_o == $past(ld_data_i));

  // R4
  pop_moves_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !unf_o && full[top]) |=> top_o == $past(top_o) + 1'b1);

  // R6
  no_overflow_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> top_o == $past(top_o));

  // R7
  no_underflow_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |-> top_o == $past(top_o));

  // R8
  xchg_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_ok |=> $stable(top_o) && st_data_o == $past(slot[x_phys]));

  // R9
  one_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ovf_o, unf_o}) <= 1);
endmodule

// File: tb/fp_reg_stack_test.sv
module fp_reg_stack_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    op_i = 2'b00;
  logic [2:0]    idx_i = '0;
  logic [DW-1:0] ld_data_i = '0;
  logic [2:0]    ra_idx_i = '0;
  logic [2:0]    rb_idx_i = '0;
  logic [DW-1:0] st_data_o, ra_data_o, rb_data_o;
  logic          ra_full_o, rb_full_o, ovf_o, unf_o;
  logic [2:0]    top_o;

  fp_reg_stack #(.DW(DW), .NREG(8)) uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .idx_i(idx_i), .ld_data_i(ld_data_i),
    .ra_idx_i(ra_idx_i), .rb_idx_i(rb_idx_i), .st_data_o(st_data_o),
    .ra_data_o(ra_data_o), .ra_full_o(ra_full_o), .rb_data_o(rb_data_o),
    .rb_full_o(rb_full_o), .top_o(top_o), .ovf_o(ovf_o), .unf_o(unf_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [DW-1:0] q[$];
  int  m_top = 0;
  bit  m_ovf = 0, m_unf = 0;
  int  checks = 0, fails = 0;
  int  cycles = 0;
  bit  done = 0;

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    chk(req, "top", DW'(top_o), DW'(m_top));
    chk(req, "ovf", DW'(ovf_o), DW'(m_ovf));
    chk(req, "unf", DW'(unf_o), DW'(m_unf));
    if (q.size() > 0) chk(req, "st0", st_data_o, q[0]);
    chk(req, "ra_full", DW'(ra_full_o), DW'(int'(ra_idx_i) < q.size()));
    chk(req, "rb_full", DW'(rb_full_o), DW'(int'(rb_idx_i) < q.size()));
    if (int'(ra_idx_i) < q.size()) chk(req, "ra_data R2", ra_data_o, q[ra_idx_i]);
    if (int'(rb_idx_i) < q.size()) chk(req, "rb_data R2", rb_data_o, q[rb_idx_i]);
  endtask

  task automatic step(string req, logic [1:0] op, int idx, logic [DW-1:0] d, int ra, int rb);
    logic [DW-1:0] t;
    @(negedge clk);
    op_i = op; idx_i = 3'(idx); ld_data_i = d; ra_idx_i = 3'(ra); rb_idx_i = 3'(rb);
    m_ovf = 0; m_unf = 0;
    case (op)
      2'b01: if (q.size() == 8) m_ovf = 1; else begin q.push_front(d); m_top = (m_top + 7) % 8; end
      2'b10: if (q.size() == 0) m_unf = 1; else begin void'(q.pop_front()); m_top = (m_top + 1) % 8; end
      2'b11: if (idx >= q.size()) m_unf = 1; else begin t = q[0]; q[0] = q[idx]; q[idx] = t; end
      default: ;
    endcase
    @(posedge clk);
    #1;
    compare(req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset top", DW'(top_o), 0);
    chk("R1", "reset ra_full", DW'(ra_full_o), 0);
    chk("R1", "reset rb_full", DW'(rb_full_o), 0);
    chk("R1", "reset ovf", DW'(ovf_o), 0);
    chk("R1", "reset unf", DW'(unf_o), 0);
    @(negedge clk); rst_n = 1;

    step("R7", 2'b10, 0, 0, 0, 1);
    step("R9", 2'b00, 0, 0, 0, 1);
    step("R7", 2'b11, 0, 0, 0, 0);
    step("R3", 2'b01, 0, 64'h1111, 0, 1);
    step("R3", 2'b01, 0, 64'h2222, 0, 1);
    step("R3", 2'b01, 0, 64'h3333, 1, 2);
    step("R2", 2'b00, 0, 0, 2, 3);
    step("R8", 2'b11, 2, 0, 0, 2);
    step("R8", 2'b11, 0, 0, 0, 1);
    step("R7", 2'b11, 5, 0, 5, 0);
    step("R5", 2'b01, 0, 64'h4444, 0, 3);
    step("R5", 2'b10, 0, 0, 0, 2);
    step("R4", 2'b10, 0, 0, 0, 1);
    for (int k = 0; k < 7; k++) step("R3", 2'b01, 0, 64'hA000 + k, k, 7 - k);
    step("R6", 2'b01, 0, 64'hDEAD, 0, 7);
    step("R6", 2'b00, 0, 0, 3, 4);
    step("R8", 2'b11, 7, 0, 0, 7);
    for (int k = 0; k < 8; k++) step("R4", 2'b10, 0, 0, 0, 1);
    step("R7", 2'b10, 0, 0, 0, 0);
    step("R9", 2'b01, 0, 64'h5555, 0, 1);
    for (int k = 0; k < 400; k++) begin
      int r = int'($urandom_range(0, 9));
      logic [1:0] op = (r < 4) ? 2'b01 : (r < 7) ? 2'b10 : (r < 9) ? 2'b11 : 2'b00;
      step("R2", op, int'($urandom_range(0, 7)), {$urandom, $urandom},
           int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule